// File: doc/BRIEF.md
# Tile Matrix Multiply-Accumulate Engine

This block keeps a bank of two-dimensional register tiles and runs one operation on them: it multiplies a source tile A by a source tile B and adds the product into a destination tile C, so that C ends up holding C + A·B. Operands are signed 8-bit integers. Sums are kept as 32-bit integers that wrap on overflow. A tile is a stack of rows of fixed byte width. With the default sizes there are 8 tiles, each made of 16 rows of 64 bytes.

A command names the destination index, the two source indices and an element-type code, and starts with a single-cycle pulse. The engine then writes one finished row of C on each clock cycle. When the last row has been written it raises a done pulse. The command is refused, and nothing changes, if its element type is not signed 8-bit or if its destination is also one of its sources. Software fills and drains tiles through a row-write port and a combinational row-read port. The row-write port is locked out while an operation runs.

Tile layouts for the default sizes:
- Row n of A holds A[n][j] in byte j, so the inner dimension J is 64.
- B is stored packed. Element B[j][m] sits in tile row j/4, at byte 4m + (j mod 4), so B's 64 rows fit in 16 tile rows.
- Row n of C holds sixteen 32-bit little-endian lanes. Lane m occupies bits 32m+31 down to 32m.

Top module: `tmac_engine`

## Requirements
- R1: While rst_n is low and after it is released, busy, done and err are all low until a command arrives.
- R2: When wr_en is high at a rising edge while the engine is idle, wr_data is written into row wr_row of tile wr_tile. rd_data always shows row rd_row of tile rd_tile combinationally.
- R3: An accepted command sets every lane m of every row n of C to C[n][m] plus the sum over j = 0..63 of A[n][j]·B[j][m]. Operands are signed 8-bit, the sum wraps at 32 bits, and A, B and C use the layouts given above.
- R4: C is added to and never cleared, so two back-to-back commands into the same C accumulate twice.
- R5: A command is accepted at the edge where start is seen while idle. busy is high for exactly 16 cycles after that edge. done is high for exactly the one cycle that follows the last busy cycle, and busy is low while done is high.
- R6: A start pulse while busy is ignored. It raises no err, does not stretch the operation, and writes no tile.
- R7: If cmd_dst equals cmd_src_a or cmd_src_b, the command is rejected: err is high for the cycle after the start edge, busy stays low, and no tile changes.
- R8: If cmd_type is not 0 (the signed 8-bit code), the command is rejected in the same way as R7.
- R9: The row-write port is ignored while busy is high.
- R10: An accepted command leaves both source tiles and every tile other than its destination unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start pulse |
| cmd_dst | input | 3 | Destination (accumulator) tile index |
| cmd_src_a | input | 3 | Left operand tile index |
| cmd_src_b | input | 3 | Right operand tile index (packed layout) |
| cmd_type | input | 2 | Element type code, 0 = signed 8-bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle command rejection pulse |
| wr_en | input | 1 | Row write enable |
| wr_tile | input | 3 | Row write tile index |
| wr_row | input | 4 | Row write row index |
| wr_data | input | 512 | Row write data |
| rd_tile | input | 3 | Row read tile index |
| rd_row | input | 4 | Row read row index |
| rd_data | output | 512 | Row read data |

## Verification
A row counter that skips or repeats a value shows up at the read port as a C row that is either never accumulated or accumulated twice. It also changes how long busy stays high, so the error is visible in the done timing as soon as the command ends. A wrong byte or lane index in the dot product corrupts every lane of the affected rows. Random tiles expose it on the first readback after the first command. A bad sign extension only shows up with negative operands, so the all-0x80 and mixed-sign corner tiles report it through fixed expected constants. A missing lockout of the write port or of start while busy shows up when the bench reads back the tile that was targeted during the operation.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
  typedef enum logic [1:0] {
    ELEM_S8   = 2'd0,
    ELEM_BF16 = 2'd1,
    ELEM_F16  = 2'd2,
    ELEM_CF16 = 2'd3
  } elem_e;

  localparam int ACC_W = 32;  // accumulator lane width
  localparam int GRP   = 4;   // inner-dimension bytes per packed lane of B
endpackage

// File: rtl/tmac_tile_file.sv
module tmac_tile_file
  import tmac_pkg::*;
#(
  parameter int TILES     = 8,
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  localparam int IDX_W    = $clog2(TILES),
  localparam int RIDX_W   = $clog2(ROWS),
  localparam int ROW_BITS = ROW_BYTES * 8
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [IDX_W-1:0]               w_tile,
  input  logic [RIDX_W-1:0]              w_row,
  input  logic [ROW_BITS-1:0]            w_data,
  input  logic [IDX_W-1:0]               r_tile,
  input  logic [RIDX_W-1:0]              r_row,
  output logic [ROW_BITS-1:0]            r_data,
  input  logic [RIDX_W-1:0]              op_row,
  input  logic [IDX_W-1:0]               a_idx,
  input  logic [IDX_W-1:0]               c_idx,
  input  logic [IDX_W-1:0]               b_idx,
  output logic [ROW_BITS-1:0]            a_row,
  output logic [ROW_BITS-1:0]            c_row,
  output logic [ROWS-1:0][ROW_BITS-1:0]  b_tile
);
  logic [ROW_BITS-1:0] mem_q [TILES][ROWS];

  // storage: clock-enabled row write, no reset on data
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[w_tile][w_row] <= w_data;
    end
  end

  assign r_data = mem_q[r_tile][r_row];
  assign a_row  = mem_q[a_idx][op_row];
  assign c_row  = mem_q[c_idx][op_row];

  for (genvar r = 0; r < ROWS; r++) begin : g_brow
    assign b_tile[r] = mem_q[b_idx][r];
  end
endmodule

// File: rtl/tmac_row_dot.sv
module tmac_row_dot
  import tmac_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  localparam int ROW_BITS = ROW_BYTES * 8,
  localparam int INNER    = ROW_BYTES,
  localparam int COLS     = ROW_BYTES / GRP
) (
  input  logic [ROW_BITS-1:0]           a_row,
  input  logic [ROWS-1:0][ROW_BITS-1:0] b_tile,
  input  logic [ROW_BITS-1:0]           c_row,
  output logic [ROW_BITS-1:0]           new_row
);
  for (genvar m = 0; m < COLS; m++) begin : g_col
    logic signed [ACC_W-1:0] acc_s;
    logic signed [15:0]      prod_s;

    always_comb begin
      acc_s  = c_row[m*ACC_W +: ACC_W];
      prod_s = '0;
      for (int j = 0; j < INNER; j++) begin
        // B element (j, m) is byte GRP*m + j%GRP of packed row j/GRP
        prod_s = $signed(a_row[8*j +: 8]) *
                 $signed(b_tile[j/GRP][8*(GRP*m + (j % GRP)) +: 8]);
        acc_s  = acc_s + ACC_W'(prod_s);
      end
    end

    assign new_row[m*ACC_W +: ACC_W] = acc_s;
  end
endmodule

// File: rtl/tmac_ctrl.sv
module tmac_ctrl
  import tmac_pkg::*;
#(
  parameter int TILES   = 8,
  parameter int ROWS    = 16,
  localparam int IDX_W  = $clog2(TILES),
  localparam int RIDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  dst,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  input  logic [1:0]        typ,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [RIDX_W-1:0] row_o,
  output logic [IDX_W-1:0]  dst_o,
  output logic [IDX_W-1:0]  a_o,
  output logic [IDX_W-1:0]  b_o
);
  localparam logic [RIDX_W-1:0] LAST_ROW = RIDX_W'(ROWS - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              err_q,  err_d;
  logic [RIDX_W-1:0] row_q,  row_d;
  logic [IDX_W-1:0]  dst_q, a_q, b_q;
  logic              cmd_ok, accept, last;

  always_comb begin
    cmd_ok = (typ == ELEM_S8) && (dst != src_a) && (dst != src_b);
    accept = start && !busy_q && cmd_ok;
    last   = busy_q && (row_q == LAST_ROW);
    busy_d = accept || (busy_q && !last);
    done_d = last;
    err_d  = start && !busy_q && !cmd_ok;
    if (accept) begin
      row_d = '0;
    end else if (busy_q) begin
      row_d = row_q + 1'b1;
    end else begin
      row_d = row_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      row_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      row_q  <= row_d;
    end
  end

  // command fields: captured on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (accept) begin
      dst_q <= dst;
      a_q   <= src_a;
      b_q   <= src_b;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign row_o  = row_q;
  assign dst_o  = dst_q;
  assign a_o    = a_q;
  assign b_o    = b_q;
endmodule

// File: rtl/tmac_engine.sv
module tmac_engine
  import tmac_pkg::*;
#(
  parameter int TILES     = 8,
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  localparam int IDX_W    = $clog2(TILES),
  localparam int RIDX_W   = $clog2(ROWS),
  localparam int ROW_BITS = ROW_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [IDX_W-1:0]    cmd_dst,
  input  logic [IDX_W-1:0]    cmd_src_a,
  input  logic [IDX_W-1:0]    cmd_src_b,
  input  logic [1:0]          cmd_type,
  output logic                busy,
  output logic                done,
  output logic                err,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_tile,
  input  logic [RIDX_W-1:0]   wr_row,
  input  logic [ROW_BITS-1:0] wr_data,
  input  logic [IDX_W-1:0]    rd_tile,
  input  logic [RIDX_W-1:0]   rd_row,
  output logic [ROW_BITS-1:0] rd_data
);
  logic [RIDX_W-1:0]           op_row;
  logic [IDX_W-1:0]            op_dst, op_a, op_b;
  logic [ROW_BITS-1:0]         a_row, c_row, acc_row;
  logic [ROWS-1:0][ROW_BITS-1:0] b_tile;
  logic                        f_we;
  logic [IDX_W-1:0]            f_tile;
  logic [RIDX_W-1:0]           f_row;
  logic [ROW_BITS-1:0]         f_data;

  tmac_ctrl #(.TILES(TILES), .ROWS(ROWS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .dst    (cmd_dst),
    .src_a  (cmd_src_a),
    .src_b  (cmd_src_b),
    .typ    (cmd_type),
    .busy_o (busy),
    .done_o (done),
    .err_o  (err),
    .row_o  (op_row),
    .dst_o  (op_dst),
    .a_o    (op_a),
    .b_o    (op_b)
  );

  // engine owns the write port while busy; external writes are dropped
  always_comb begin
    f_we   = busy || wr_en;
    f_tile = busy ? op_dst  : wr_tile;
    f_row  = busy ? op_row  : wr_row;
    f_data = busy ? acc_row : wr_data;
  end

  tmac_tile_file #(.TILES(TILES), .ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_file (
    .clk    (clk),
    .we     (f_we),
    .w_tile (f_tile),
    .w_row  (f_row),
    .w_data (f_data),
    .r_tile (rd_tile),
    .r_row  (rd_row),
    .r_data (rd_data),
    .op_row (op_row),
    .a_idx  (op_a),
    .c_idx  (op_dst),
    .b_idx  (op_b),
    .a_row  (a_row),
    .c_row  (c_row),
    .b_tile (b_tile)
  );

  tmac_row_dot #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_dot (
    .a_row   (a_row),
    .b_tile  (b_tile),
    .c_row   (c_row),
    .new_row (acc_row)
  );
endmodule

// File: rtl/tmac_chk.sv
module tmac_chk #(
  parameter int ROWS  = 16,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] cmd_dst,
  input logic [IDX_W-1:0] cmd_src_a,
  input logic [IDX_W-1:0] cmd_src_b,
  input logic [1:0]       cmd_type,
  input logic             busy,
  input logic             done,
  input logic             err
);
  localparam int CNT_W = $clog2(ROWS + 1) + 1;
  logic [CNT_W-1:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
    end else if (busy) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end else begin
      busy_cnt_q <= '0;
    end
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt_q == CNT_W'(ROWS)));                              // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                             // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));                                            // R5
  AST_BUSY_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);                                                   // R6
  AST_ALIAS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (cmd_dst == cmd_src_a || cmd_dst == cmd_src_b)) |=> (err && !busy)); // R7
  AST_TYPE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd_type != 2'd0) |=> (err && !busy));                    // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(start) && !$past(busy)));                                     // R7
endmodule

bind tmac_engine tmac_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cmd_dst   (cmd_dst),
  .cmd_src_a (cmd_src_a),
  .cmd_src_b (cmd_src_b),
  .cmd_type  (cmd_type),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/sim_tmac_engine.sv
`timescale 1ns/1ps
module sim_tmac_engine;
  localparam int TILES = 8;
  localparam int ROWS  = 16;
  localparam int RB    = 64;
  localparam int RBITS = RB * 8;
  localparam int NVEC  = 8;

  // vector: {dst[3], src_a[3], src_b[3], type[2], expect_reject[1]}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd2, 3'd0, 3'd1, 2'd0, 1'b0},  // R3 plain accumulate
    {3'd2, 3'd0, 3'd1, 2'd0, 1'b0},  // R4 same C again
    {3'd3, 3'd1, 3'd0, 2'd0, 1'b0},  // R3 swapped operands
    {3'd4, 3'd4, 3'd1, 2'd0, 1'b1},  // R7 dst == src_a
    {3'd5, 3'd0, 3'd5, 2'd0, 1'b1},  // R7 dst == src_b
    {3'd6, 3'd0, 3'd1, 2'd1, 1'b1},  // R8 bad type
    {3'd6, 3'd0, 3'd0, 2'd0, 1'b0},  // R3 A and B same tile
    {3'd5, 3'd3, 3'd2, 2'd3, 1'b1}   // R8 bad type
  };

  logic             clk, rst_n, start, busy, done, err, wr_en;
  logic [2:0]       cmd_dst, cmd_src_a, cmd_src_b, wr_tile, rd_tile;
  logic [1:0]       cmd_type;
  logic [3:0]       wr_row, rd_row;
  logic [RBITS-1:0] wr_data, rd_data;

  logic [RBITS-1:0] mdl [TILES][ROWS];
  int n_cmp, n_bad;

  tmac_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_dst(cmd_dst),
    .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_type(cmd_type),
    .busy(busy), .done(done), .err(err), .wr_en(wr_en), .wr_tile(wr_tile),
    .wr_row(wr_row), .wr_data(wr_data), .rd_tile(rd_tile), .rd_row(rd_row),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk_val(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic chk_row(input string req, input int t, input int r,
                         input logic [RBITS-1:0] got, input logic [RBITS-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s tile %0d row %0d got %h exp %h", req, t, r, got, exp);
    end
  endtask

  task automatic write_row(input int t, input int r, input logic [RBITS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tile = 3'(t); wr_row = 4'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[t][r] = d;
  endtask

  task automatic fill_tile(input int t, input logic [RBITS-1:0] d);
    for (int r = 0; r < ROWS; r++) write_row(t, r, d);
  endtask

  task automatic check_all(input int dst, input string dtag, input string otag);
    for (int t = 0; t < TILES; t++) begin
      for (int r = 0; r < ROWS; r++) begin
        rd_tile = 3'(t); rd_row = 4'(r);
        #0.5;
        chk_row((t == dst) ? dtag : otag, t, r, rd_data, mdl[t][r]);
      end
    end
    @(negedge clk);
  endtask

  // behavioural triple loop, written from R3
  task automatic ref_mac(input int c, input int a, input int b);
    for (int n = 0; n < ROWS; n++) begin
      for (int m = 0; m < RB / 4; m++) begin
        int acc;
        acc = int'(mdl[c][n][32*m +: 32]);
        for (int j = 0; j < RB; j++) begin
          logic signed [7:0] av, bv;
          av = mdl[a][n][8*j +: 8];
          bv = mdl[b][j/4][8*(4*m + j%4) +: 8];
          acc = acc + int'(av) * int'(bv);
        end
        mdl[c][n][32*m +: 32] = acc;
      end
    end
  endtask

  task automatic run_cmd(input int d, input int a, input int b, input int ty,
                         input bit reject, input bit inject, input string rtag);
    int cyc;
    bit saw_err;
    if (!reject) ref_mac(d, a, b);
    @(negedge clk);
    start = 1'b1; cmd_dst = 3'(d); cmd_src_a = 3'(a); cmd_src_b = 3'(b);
    cmd_type = 2'(ty);
    @(negedge clk);
    start = 1'b0;
    if (reject) begin
      chk_val({rtag, " err raised"}, int'(err), 1);
      chk_val({rtag, " busy low"}, int'(busy), 0);
      @(negedge clk);
      chk_val({rtag, " err single"}, int'(err), 0);
      return;
    end
    chk_val("R5 busy after start", int'(busy), 1);
    cyc = 0; saw_err = 1'b0;
    while (busy === 1'b1 && cyc < 40) begin
      if (inject && cyc == 4) begin
        start = 1'b1; cmd_dst = 3'd7; cmd_src_a = 3'd0; cmd_src_b = 3'd1;
        cmd_type = 2'd0;
        wr_en = 1'b1; wr_tile = 3'd7; wr_row = 4'd3; wr_data = ~mdl[7][3];
      end
      @(negedge clk);
      cyc++;
      start = 1'b0; wr_en = 1'b0;
      if (err === 1'b1) saw_err = 1'b1;
    end
    chk_val("R5 busy span", cyc, ROWS);
    chk_val("R5 done after busy", int'(done), 1);
    if (inject) chk_val("R6 no err on busy start", int'(saw_err), 0);
    @(negedge clk);
    chk_val("R5 done one cycle", int'(done), 0);
    chk_val("R6 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0;
    cmd_dst = '0; cmd_src_a = '0; cmd_src_b = '0; cmd_type = '0;
    wr_tile = '0; wr_row = '0; wr_data = '0; rd_tile = '0; rd_row = '0;
    repeat (3) @(negedge clk);
    chk_val("R1 busy in reset", int'(busy), 0);
    chk_val("R1 done in reset", int'(done), 0);
    chk_val("R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_val("R1 idle after reset", int'(busy | done | err), 0);

    for (int t = 0; t < TILES; t++)
      for (int r = 0; r < ROWS; r++)
        write_row(t, r, {16{$urandom()}} ^ {$urandom(), 480'd0} ^ RBITS'($urandom()));
    check_all(-1, "R2", "R2 row readback");

    for (int i = 0; i < NVEC; i++) begin
      int d, a, b, ty;
      bit rj;
      d  = int'(VEC[i][11:9]); a = int'(VEC[i][8:6]); b = int'(VEC[i][5:3]);
      ty = int'(VEC[i][2:1]);  rj = VEC[i][0];
      run_cmd(d, a, b, ty, rj, 1'b0, (ty != 0) ? "R8" : "R7");
      check_all(rj ? -1 : d, (i == 1) ? "R4 accumulate" : "R3 result",
                rj ? ((ty != 0) ? "R8 no tile changed" : "R7 no tile changed")
                   : "R10 others untouched");
    end

    // signed extremes with wrap: (-128)*(-128)*64 on top of 0x7FFFFFFF
    fill_tile(0, {RB{8'h80}});
    fill_tile(1, {RB{8'h80}});
    fill_tile(3, {16{32'h7FFF_FFFF}});
    run_cmd(3, 0, 1, 0, 1'b0, 1'b0, "R3");
    rd_tile = 3'd3; rd_row = 4'd0; #0.5;
    chk_row("R3 wrap corner", 3, 0, rd_data, {16{32'h800F_FFFF}});
    check_all(3, "R3 wrap", "R10 others untouched");

    // mixed sign: 127 * (-128) * 64 into zero
    fill_tile(0, {RB{8'h7F}});
    fill_tile(4, '0);
    run_cmd(4, 0, 1, 0, 1'b0, 1'b0, "R3");
    rd_tile = 3'd4; rd_row = 4'd15; #0.5;
    chk_row("R3 mixed sign", 4, 15, rd_data, {16{32'hFFF0_2000}});
    check_all(4, "R3 mixed", "R10 others untouched");

    // start and row write during busy must be ignored
    run_cmd(2, 0, 1, 0, 1'b0, 1'b1, "R6");
    check_all(2, "R3 result", "R9 R6 tile 7 untouched");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule